// File: doc/BRIEF.md
# Line Period Meter

This block measures how long one line cycle of a chosen phase voltage lasts. It counts the pulses of a 256 kHz timebase enable that fall between two successive crossings of the selected phase. The crossings arrive as single-cycle strobes from an upstream filter, and each strobe marks crossings of the same direction. Each finished count is placed in a 16-bit unsigned period register. One LSB is one timebase tick, or 3.90625 µs. A steady 50 Hz line therefore reads about 5120, and a steady 60 Hz line reads about 4267.

A 2-bit select picks the phase and may change at run time. After a change, the interval that is already in progress is thrown away. The register is refreshed only once a full cycle of the new phase has been timed. If no crossing arrives for longer than a full 16-bit count, which is below about 3.9 Hz, the register is loaded with all ones. A one-cycle update strobe goes with every load of the register.

Top module: `line_period_meter`

## Requirements
- R1: After reset, `period` is 0 and `period_upd` is 0.
- R2: `phase_sel` values 00, 01 and 10 pick the crossing strobe `zc[0]`, `zc[1]` and `zc[2]` respectively. Crossing strobes of the phases that are not selected have no effect on `period` or `period_upd`.
- R3: `phase_sel` value 11 picks `zc[0]`, the same phase as 00.
- R4: When a crossing of the selected phase is sampled on a clock edge and a previous crossing of that phase has been seen, `period` takes the number of cycles with `tick` high that fell strictly between the two crossings. `period_upd` is high for that one cycle.
- R5: `period` changes only in a cycle where `period_upd` is high. Exactly one update occurs per accepted crossing.
- R6: The first crossing of the selected phase after reset starts timing and produces no update.
- R7: After `phase_sel` changes to a different phase, the first crossing of the new phase produces no update. The second crossing produces the first update, and it times only the interval between those two crossings.
- R8: If 65536 or more ticks pass between two accepted crossings, `period` is loaded with 0xFFFF. The next period is then measured normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Timebase enable, one cycle high per 256 kHz tick |
| zc | input | 3 | Per-phase crossing strobes; bit 0 is phase A, bit 1 is B, bit 2 is C |
| phase_sel | input | 2 | Selects the measured phase (11 is treated as phase A) |
| period | output | 16 | Last measured period in ticks |
| period_upd | output | 1 | One-cycle pulse on each load of `period` |

## Verification
The bench sends crossing strobes of the phases that are not selected while a period is being timed. A design that muxed the wrong bit would restart its count and report short periods. It switches the select and checks that the first crossing of the new phase raises no update. A design that kept its old arming would report a stretch of time that spans two phases. It drives select 11 expecting phase A behaviour, and it runs a gap longer than the full count range. A counter that wrapped instead of saturating would report a small number rather than 0xFFFF. It also confirms that the period that follows the overflow is back to normal.

// File: rtl/line_period_meter.sv
module line_period_meter #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic [2:0]    zc,
  input  logic [1:0]    phase_sel,
  output logic [CW-1:0] period,
  output logic          period_upd
);

  localparam logic [CW-1:0] FULL = {CW{1'b1}};

  logic [1:0]    src, src_q;
  logic          edge_hit, chg, armed, ovf;
  logic [CW-1:0] cnt;

  assign src      = (phase_sel == 2'b11) ? 2'b00 : phase_sel;
  assign chg      = (src != src_q);
  assign edge_hit = zc[src];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_q      <= 2'b00;
      armed      <= 1'b0;
      ovf        <= 1'b0;
      cnt        <= '0;
      period     <= '0;
      period_upd <= 1'b0;
    end else begin
      src_q      <= src;
      period_upd <= 1'b0;
      if (chg) begin
        armed <= 1'b0;
        ovf   <= 1'b0;
        cnt   <= '0;
      end else if (edge_hit) begin
        if (armed) begin
          period     <= ovf ? FULL : cnt;
          period_upd <= 1'b1;
        end
        armed <= 1'b1;
        ovf   <= 1'b0;
        cnt   <= '0;
      end else if (armed && tick) begin
        if (cnt == FULL) ovf <= 1'b1;
        else             cnt <= cnt + 1'b1;
      end
    end
  end

  AST_PERIOD_ONLY_ON_UPD: assert property (@(posedge clk) disable iff (!rst_n)
    (period != $past(period)) |-> period_upd); // R5
  AST_FIRST_EDGE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_hit && !armed) |=> !period_upd); // R6
  AST_SEL_CHANGE_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
    chg |=> (!armed && !period_upd)); // R7
  AST_OVF_LOADS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_hit && armed && ovf && !chg) |=> (period_upd && period == FULL)); // R8
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !edge_hit && !chg) |=> ovf); // R8

endmodule

// File: tb/line_period_meter_test.sv
module line_period_meter_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic [2:0]  zc = 3'b000;
  logic [1:0]  phase_sel = 2'b00;
  logic [15:0] period;
  logic        period_upd;

  int checks = 0;
  int fails  = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];
  bit          done = 1'b0;

  always #5 clk = ~clk;

  line_period_meter uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .zc(zc),
    .phase_sel(phase_sel), .period(period), .period_upd(period_upd)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: pops and compares on every update
  always @(negedge clk) begin
    if (rst_n && period_upd) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R5/R6/R7 unexpected update", period, -1);
      end else begin
        logic [15:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(period == e, t, period, e);
      end
    end
  end

  task automatic crossing(input int ph);
    @(negedge clk);
    tick = 1'b0;
    zc = 3'b000;
    zc[ph] = 1'b1;
    @(negedge clk);
    zc = 3'b000;
  endtask

  // n ticks; gap cycles between ticks; optional distractor crossings on other phases
  task automatic run_ticks(input int n, input int gap, input int sel_ph, input bit noise);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tick = 1'b1;
      zc = 3'b000;
      @(negedge clk);
      tick = 1'b0;
      if (noise && (i % 97 == 5)) zc = ~(3'b001 << sel_ph);
      for (int g = 1; g < gap; g++) begin
        @(negedge clk);
        zc = 3'b000;
      end
      zc = 3'b000;
    end
  endtask

  task automatic period_expect(input int ph, input int n, input bit noise, input string t);
    run_ticks(n, 2, ph, noise);
    exp_q.push_back((n > 65535) ? 16'hFFFF : n[15:0]);
    tag_q.push_back(t);
    crossing(ph);
  endtask

  task automatic drain();
    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R5 pending updates", exp_q.size(), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(period == 16'd0, "R1 period", period, 0);
    check(period_upd == 1'b0, "R1 upd", period_upd, 0);
    rst_n = 1'b1;

    // phase A via 00
    phase_sel = 2'b00;
    run_ticks(40, 2, 0, 1'b0);
    crossing(0);                               // R6 arms only
    drain();
    period_expect(0, 5120, 1'b1, "R2 R4 phase A 50Hz");
    period_expect(0, 4267, 1'b1, "R4 phase A 60Hz");
    drain();
    run_ticks(30, 3, 0, 1'b1);
    check(period == 16'd4267, "R5 hold", period, 4267);

    // phase B
    phase_sel = 2'b01;
    run_ticks(25, 2, 1, 1'b0);
    crossing(1);                               // R7 discarded
    drain();
    period_expect(1, 300, 1'b1, "R7 R2 phase B");
    period_expect(1, 1, 1'b0, "R4 single tick");
    drain();

    // phase C
    phase_sel = 2'b10;
    crossing(2);
    drain();
    period_expect(2, 2000, 1'b1, "R2 phase C");
    period_expect(2, 0, 1'b0, "R4 zero ticks");
    drain();

    // select 11 behaves as A
    phase_sel = 2'b11;
    crossing(1);
    crossing(2);
    crossing(0);                               // R7 first A after change
    drain();
    period_expect(0, 777, 1'b1, "R3 sel 11 is A");
    drain();

    // overflow
    @(negedge clk);
    tick = 1'b1;
    repeat (66000) @(negedge clk);
    tick = 1'b0;
    exp_q.push_back(16'hFFFF);
    tag_q.push_back("R8 saturate");
    crossing(0);
    drain();
    period_expect(0, 100, 1'b0, "R8 recover");
    drain();

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (190000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule